// File: doc/BRIEF.md
# Serial Booth Fractional Multiplier

This block multiplies two 20-bit two's complement fractions (Q0.19) that arrive one bit per clock on two serial lines. It returns the product on one serial line in the same 20-bit word framing. A strobe marks the first bit-time of every word. Bits travel least significant first.

Three register groups work on different words in the same word time, so a new operand pair can be accepted every word time:
- an input shifter collects the next pair;
- a working accumulator runs a radix-2 Booth multiply on the pair captured one word earlier, one recoding step per bit-time;
- an output shifter sends the result of the pair before that.

Each product leaves two word times after its operands went in. The result is the upper half of the 40-bit product, aligned as a Q0.19 fraction and truncated toward minus infinity. The one product that cannot be represented, minus one times minus one, is clamped to the largest positive fraction.

Top module: `serial_booth_mul`

## Requirements
- R1: After reset the serial output is 0. It stays 0 through the first two framed words following the first strobe.
- R2: A word is 20 bit-times long. The strobe is high during bit-time 0 only. Bit j of each operand is sampled, and bit j of the result is driven, during bit-time j, least significant bit first.
- R3: The result equals bits 38 down to 19 of the signed 40-bit product of the two operands. This is floor(a*b / 2^19) read as a 20-bit two's complement value.
- R4: The result for the operands sent in word k appears on the output during word k+2.
- R5: Words may follow back to back with no gap. Every word yields a result, so one product completes per word time.
- R6: The operands 0x80000 and 0x80000 (minus one times minus one) give 0x7FFFF. The output word 0x80000 only ever comes from an operand pair whose true product is -1.
- R7: Once framing has begun, consecutive strobes are exactly 20 bit-times apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_strobe | input | 1 | High during bit-time 0 of each word |
| ser_a | input | 1 | Multiplicand serial data, LSB first |
| ser_b | input | 1 | Multiplier serial data, LSB first |
| ser_y | output | 1 | Product serial data, LSB first |

## Verification
The assertions assume that once the first strobe has arrived, the strobe recurs exactly every 20 clocks. The design finds word ends by counting bit-times from each strobe and never checks this by itself. The stimulus sends every word back to back with the strobe on bit 0, from the first word until the bench ends. It never stops strobing in the middle of a word and never lets two strobes come closer than 20 bit-times. The operands cover the directed corner pairs (minus one squared, extreme magnitudes, the smallest magnitudes of either sign) and a long run of pseudo-random words.

// File: rtl/serial_booth_mul.sv
module serial_booth_mul #(
  parameter int W = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic word_strobe,
  input  logic ser_a,
  input  logic ser_b,
  output logic ser_y
);
  localparam int CW = $clog2(W + 1);
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] sh_a, sh_b, a_word, b_word;
  logic [CW-1:0] bit_cnt, bit_idx;
  logic synced, word_end;
  logic signed [W:0] acc, mcand, addend, sum, acc_n;
  logic [W-1:0] mq, mq_n, out_sr, result;
  logic mq_prev;

  assign a_word   = {ser_a, sh_a[W-1:1]};
  assign b_word   = {ser_b, sh_b[W-1:1]};
  assign bit_idx  = word_strobe ? '0 : bit_cnt;
  assign word_end = synced && (bit_idx == CW'(W - 1));

  always_comb begin
    case ({mq[0], mq_prev})
      2'b10:   addend = -mcand;
      2'b01:   addend = mcand;
      default: addend = '0;
    endcase
  end

  assign sum    = acc + addend;
  assign acc_n  = sum >>> 1;
  assign mq_n   = {sum[0], mq[W-1:1]};
  assign result = (acc_n[W-1] != acc_n[W-2]) ? MAX_POS : {acc_n[W-2:0], mq_n[W-1]};
  assign ser_y  = out_sr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_a    <= '0;
      sh_b    <= '0;
      bit_cnt <= '0;
      synced  <= 1'b0;
      acc     <= '0;
      mcand   <= '0;
      mq      <= '0;
      mq_prev <= 1'b0;
      out_sr  <= '0;
    end else begin
      sh_a    <= a_word;
      sh_b    <= b_word;
      bit_cnt <= bit_idx + CW'(1);
      if (word_strobe) synced <= 1'b1;
      if (word_end) begin
        acc     <= '0;
        mcand   <= $signed({a_word[W-1], a_word});
        mq      <= b_word;
        mq_prev <= 1'b0;
        out_sr  <= result;
      end else begin
        acc     <= acc_n;
        mq      <= mq_n;
        mq_prev <= mq[0];
        out_sr  <= {1'b0, out_sr[W-1:1]};
      end
    end
  end

  AST_FRAME_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (synced && word_strobe) |-> (bit_cnt == CW'(W))); // R7
  AST_STROBE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    word_end |=> word_strobe); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> !ser_y); // R1
  AST_NO_MIN_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    word_end |=> (out_sr != MIN_NEG)); // R6
  AST_WORK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    word_end |=> (acc == '0 && !mq_prev)); // R4

endmodule

// File: tb/serial_booth_mul_tb.sv
module serial_booth_mul_tb;
  localparam int W = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0;
  logic sa = 1'b0;
  logic sb = 1'b0;
  logic sy;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;
  int idx = 0;
  logic [W-1:0] cap;
  logic [W-1:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  serial_booth_mul #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .word_strobe(strobe),
    .ser_a(sa), .ser_b(sb), .ser_y(sy)
  );

  function automatic logic [W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b);
    logic signed [2*W-1:0] p;
    p = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
    if (p[2*W-1] != p[2*W-2]) return {1'b0, {(W-1){1'b1}}};
    return p[2*W-2:W-1];
  endfunction

  function automatic logic [W-1:0] lfsr_next(logic [W-1:0] s);
    return {s[W-2:0], s[19] ^ s[16]};
  endfunction

  task automatic check(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic send(logic [W-1:0] a, logic [W-1:0] b, string tag);
    exp_q.push_back(ref_mul(a, b));
    tag_q.push_back(tag);
    for (int j = 0; j < W; j++) begin
      @(negedge clk);
      strobe = (j == 0);
      sa = a[j];
      sb = b[j];
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (strobe) begin
        idx = 0;
        mon_on = 1'b1;
      end else begin
        idx = idx + 1;
      end
      if (mon_on && idx < W) begin
        cap[idx] = sy;
        if (idx == W - 1) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R5 scoreboard underflow", cap, '0);
          end else begin
            logic [W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(cap == e, t, cap, e);
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ra, rb;
    bit idle_ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle_ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      #2;
      if (sy !== 1'b0) idle_ok = 1'b0;
    end
    check(idle_ok, "R1 idle output after reset", {{(W-1){1'b0}}, sy}, '0);

    exp_q.push_back('0); tag_q.push_back("R1 first output word");
    exp_q.push_back('0); tag_q.push_back("R1 second output word");

    send(20'h40000, 20'h40000, "R3 half times half");
    send(20'hC0000, 20'h40000, "R3 negative half times half");
    send(20'h00001, 20'h00001, "R3 smallest squared truncates");
    send(20'hFFFFF, 20'h00001, "R3 floor toward minus infinity");
    send(20'h80000, 20'h80000, "R6 minus one squared");
    send(20'h80000, 20'h80000, "R6 minus one squared back to back");
    send(20'h80000, 20'h7FFFF, "R6 minus one times max");
    send(20'h7FFFF, 20'h7FFFF, "R3 max squared");
    send(20'h00000, 20'h5A5A5, "R3 zero operand");
    send(20'h00003, 20'h40000, "R2 LSB-first weighting");
    send(20'h40000, 20'h00003, "R2 LSB-first weighting swapped");
    send(20'h80000, 20'h00001, "R3 minus one times lsb");
    ra = 20'h3A5C1;
    rb = 20'h91E47;
    for (int i = 0; i < 40; i++) begin
      ra = lfsr_next(ra);
      rb = lfsr_next(lfsr_next(rb));
      send(ra, rb, (i % 2 == 0) ? "R4 pseudo-random two-word latency" : "R5 pseudo-random back to back");
    end
    send(20'h00000, 20'h00000, "R5 flush word");
    send(20'h00000, 20'h00000, "R5 flush word");
    @(negedge clk);
    #3;
    done = 1'b1;
    check(exp_q.size() == 2, "R5 one result per word",
          W'(exp_q.size()), W'(2));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule